// File: doc/BRIEF.md
# Segmented Gate Current Sequencer

This block turns the logic-level switching command of one power transistor into a drive-current code for an external programmable current-source gate stage. Each switching edge becomes a short sequence of timed segments. A turn-on runs a pre-charge segment, then a slew-control segment, then holds full source current. A turn-off mirrors this with sink currents and ends holding full sink current. All time is counted in system clock cycles.

Eight configuration registers are loaded through a parallel write port. Four hold segment durations and four hold current codes. A write only lands in a shadow copy. The running sequence works from an active copy, which takes the shadow values at the clock edge that starts the next sequence. Code value zero stands for the weakest current the stage offers, and the all-ones code stands for its full current.

The finite-state machine has six states: OFF_HOLD, ON_PRE, ON_MAIN, ON_HOLD, OFF_PRE and OFF_MAIN. It has these transitions:
- START_ON: a rising command goes to the first on-segment with a nonzero duration.
- START_OFF: a falling command goes to the first off-segment with a nonzero duration.
- PRE_DONE: the pre-charge count expires and the sequence moves on to the main segment, or to the hold state when the main duration is zero.
- MAIN_DONE: the main count expires and the sequence moves on to the hold state.
- ABORT: an opposite edge arrives while a sequence is running. It acts as START_ON or START_OFF.

Top module: `gate_slew_seq`

## Requirements
- R1: While reset is active and just after it, seg_id is 0 (OFF_HOLD), drive_src is 0 and i_code is all ones (full sink).
- R2: After pwm_in rises, starting from the first clock edge that sees it high, the block outputs seg_id 1 (ON_PRE), drive_src 1 and the code in register 4 for exactly the number of cycles in register 0.
- R3: After ON_PRE, seg_id 2 (ON_MAIN) outputs drive_src 1 and the code in register 5 for exactly the number of cycles in register 1.
- R4: After ON_MAIN, seg_id 3 (ON_HOLD) outputs drive_src 1 and the all-ones code until pwm_in falls.
- R5: A falling pwm_in gives seg_id 4 (OFF_PRE) with the register 6 code for the register 2 duration. Then seg_id 5 (OFF_MAIN) gives the register 7 code for the register 3 duration. Then seg_id 0 gives the all-ones sink code. drive_src is 0 in all three.
- R6: A segment whose duration is zero never appears on seg_id, not even for one cycle. The next segment starts in its place.
- R7: An opposite edge during a running sequence aborts it. The opposite sequence then starts from its first segment in the next cycle.
- R8: A register write has no effect on the outputs of the sequence that is running. It is used from the next edge-started sequence.
- R9: Register addresses: 0 on-pre duration, 1 on-main duration, 2 off-pre duration, 3 off-main duration, 4 source pre-charge code, 5 source main code, 6 sink pre-charge code, 7 sink main code.
- R10: seg_id never exceeds 5. drive_src is 1 exactly when seg_id is 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; durations count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Switching command, high means conduct |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index (R9) |
| wr_data | input | DATA_W | Write value, the larger of DUR_W and CODE_W |
| seg_id | output | 3 | Current segment (R10 encoding) |
| drive_src | output | 1 | 1 source current, 0 sink current |
| i_code | output | CODE_W | Current level code for the gate stage |

## Verification
The bench builds the block with DUR_W = 4 and CODE_W = 6. This makes the largest duration 15 cycles, so the all-ones duration boundary is tested directly. It also keeps every on/off trace short enough to check cycle by cycle. With these values the bench sweeps every pair of pre and main durations from 0 to 3 in both directions, which covers every skip pattern of R6. The narrow code width lets each combination use distinct codes, so a swapped register or segment shows up. Directed runs cover an abort in the middle of a segment and a write in the middle of a sequence.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
    typedef enum logic [2:0] {
        SEG_OFF_HOLD = 3'd0,
        SEG_ON_PRE   = 3'd1,
        SEG_ON_MAIN  = 3'd2,
        SEG_ON_HOLD  = 3'd3,
        SEG_OFF_PRE  = 3'd4,
        SEG_OFF_MAIN = 3'd5
    } seg_e;

    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = 3;
endpackage

// File: rtl/gsq_edge_det.sv
module gsq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    output logic rise,
    output logic fall
);
    logic pwm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_in;
    end

    assign rise = pwm_in & ~pwm_q;
    assign fall = ~pwm_in & pwm_q;
endmodule

// File: rtl/gsq_cfg_bank.sv
module gsq_cfg_bank #(
    parameter int DUR_W  = 8,
    parameter int CODE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [gsq_pkg::ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          latch,
    output logic [DUR_W-1:0]              on_pre_dur,
    output logic [DUR_W-1:0]              on_main_dur,
    output logic [DUR_W-1:0]              off_pre_dur,
    output logic [DUR_W-1:0]              off_main_dur,
    output logic [CODE_W-1:0]             src_pre_code,
    output logic [CODE_W-1:0]             src_main_code,
    output logic [CODE_W-1:0]             snk_pre_code,
    output logic [CODE_W-1:0]             snk_main_code
);
    localparam int NR = gsq_pkg::NUM_REGS;

    logic [DATA_W-1:0] shadow [NR];
    logic [DATA_W-1:0] active [NR];
    logic [DATA_W-1:0] eff    [NR];

    for (genvar g = 0; g < NR; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[g] <= '0;
                active[g] <= '0;
            end else begin
                if (wr_en && wr_addr == gsq_pkg::ADDR_W'(g)) shadow[g] <= wr_data;
                if (latch) active[g] <= shadow[g];
            end
        end
        assign eff[g] = latch ? shadow[g] : active[g];
    end

    // durations seen by the sequencer: shadow on the starting edge
    assign on_pre_dur    = DUR_W'(eff[0]);
    assign on_main_dur   = DUR_W'(eff[1]);
    assign off_pre_dur   = DUR_W'(eff[2]);
    assign off_main_dur  = DUR_W'(eff[3]);
    // codes are read only while a segment is shown, so from the active copy
    assign src_pre_code  = CODE_W'(active[4]);
    assign src_main_code = CODE_W'(active[5]);
    assign snk_pre_code  = CODE_W'(active[6]);
    assign snk_main_code = CODE_W'(active[7]);
endmodule

// File: rtl/gsq_seq_fsm.sv
module gsq_seq_fsm #(
    parameter int DUR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                fall,
    input  logic [DUR_W-1:0]    on_pre_dur,
    input  logic [DUR_W-1:0]    on_main_dur,
    input  logic [DUR_W-1:0]    off_pre_dur,
    input  logic [DUR_W-1:0]    off_main_dur,
    output gsq_pkg::seg_e       state
);
    import gsq_pkg::*;

    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    seg_e             nxt;
    logic [DUR_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEG_OFF_HOLD;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = (cnt != '0) ? cnt - ONE : cnt;
        if (rise) begin                      // START_ON / ABORT
            if (on_pre_dur != '0)       begin nxt = SEG_ON_PRE;  cnt_nxt = on_pre_dur - ONE;  end
            else if (on_main_dur != '0) begin nxt = SEG_ON_MAIN; cnt_nxt = on_main_dur - ONE; end
            else                        begin nxt = SEG_ON_HOLD; cnt_nxt = '0;                end
        end else if (fall) begin             // START_OFF / ABORT
            if (off_pre_dur != '0)       begin nxt = SEG_OFF_PRE;  cnt_nxt = off_pre_dur - ONE;  end
            else if (off_main_dur != '0) begin nxt = SEG_OFF_MAIN; cnt_nxt = off_main_dur - ONE; end
            else                         begin nxt = SEG_OFF_HOLD; cnt_nxt = '0;                 end
        end else begin
            unique case (state)
                SEG_ON_PRE: if (cnt == '0) begin         // PRE_DONE
                    if (on_main_dur != '0) begin nxt = SEG_ON_MAIN; cnt_nxt = on_main_dur - ONE; end
                    else                         nxt = SEG_ON_HOLD;
                end
                SEG_ON_MAIN:  if (cnt == '0) nxt = SEG_ON_HOLD;   // MAIN_DONE
                SEG_OFF_PRE: if (cnt == '0) begin
                    if (off_main_dur != '0) begin nxt = SEG_OFF_MAIN; cnt_nxt = off_main_dur - ONE; end
                    else                          nxt = SEG_OFF_HOLD;
                end
                SEG_OFF_MAIN: if (cnt == '0) nxt = SEG_OFF_HOLD;
                SEG_ON_HOLD, SEG_OFF_HOLD: nxt = state;
                default: nxt = SEG_OFF_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/gate_slew_seq.sv
module gate_slew_seq #(
    parameter int DUR_W  = 8,
    parameter int CODE_W = 8,
    localparam int DATA_W = (DUR_W > CODE_W) ? DUR_W : CODE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pwm_in,
    input  logic                          wr_en,
    input  logic [gsq_pkg::ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [2:0]                    seg_id,
    output logic                          drive_src,
    output logic [CODE_W-1:0]             i_code
);
    import gsq_pkg::*;

    logic              rise, fall;
    logic [DUR_W-1:0]  on_pre_dur, on_main_dur, off_pre_dur, off_main_dur;
    logic [CODE_W-1:0] src_pre_code, src_main_code, snk_pre_code, snk_main_code;
    seg_e              state;

    gsq_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .rise(rise), .fall(fall)
    );

    gsq_cfg_bank #(.DUR_W(DUR_W), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .latch(rise | fall),
        .on_pre_dur(on_pre_dur), .on_main_dur(on_main_dur),
        .off_pre_dur(off_pre_dur), .off_main_dur(off_main_dur),
        .src_pre_code(src_pre_code), .src_main_code(src_main_code),
        .snk_pre_code(snk_pre_code), .snk_main_code(snk_main_code)
    );

    gsq_seq_fsm #(.DUR_W(DUR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .on_pre_dur(on_pre_dur), .on_main_dur(on_main_dur),
        .off_pre_dur(off_pre_dur), .off_main_dur(off_main_dur),
        .state(state)
    );

    always_comb begin
        seg_id = state;
        unique case (state)
            SEG_ON_PRE:   begin drive_src = 1'b1; i_code = src_pre_code;  end
            SEG_ON_MAIN:  begin drive_src = 1'b1; i_code = src_main_code; end
            SEG_ON_HOLD:  begin drive_src = 1'b1; i_code = '1;            end
            SEG_OFF_PRE:  begin drive_src = 1'b0; i_code = snk_pre_code;  end
            SEG_OFF_MAIN: begin drive_src = 1'b0; i_code = snk_main_code; end
            default:      begin drive_src = 1'b0; i_code = '1;            end
        endcase
    end
endmodule

// File: rtl/gsq_checker.sv
module gsq_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_in,
    input logic [2:0]        seg_id,
    input logic              drive_src,
    input logic [CODE_W-1:0] i_code
);
    a_r4_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        seg_id == 3'd3 |-> (drive_src && i_code == {CODE_W{1'b1}}));

    a_r5_offhold_full: assert property (@(posedge clk) disable iff (!rst_n)
        seg_id == 3'd0 |-> (!drive_src && i_code == {CODE_W{1'b1}}));

    a_r10_legal_seg: assert property (@(posedge clk) disable iff (!rst_n)
        seg_id <= 3'd5);

    a_r10_direction: assert property (@(posedge clk) disable iff (!rst_n)
        drive_src == (seg_id == 3'd1 || seg_id == 3'd2 || seg_id == 3'd3));

    a_r2_rise_starts_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_in) |=> (seg_id == 3'd1 || seg_id == 3'd2 || seg_id == 3'd3));

    a_r5_fall_starts_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_in) |=> (seg_id == 3'd4 || seg_id == 3'd5 || seg_id == 3'd0));

    a_r4_hold_until_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_id == 3'd3 && pwm_in) |=> seg_id == 3'd3);

    a_r5_offhold_until_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_id == 3'd0 && !pwm_in) |=> seg_id == 3'd0);
endmodule

bind gate_slew_seq gsq_checker #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .seg_id(seg_id), .drive_src(drive_src), .i_code(i_code)
);

// File: tb/gate_slew_seq_tb.sv
module gate_slew_seq_tb;
    localparam int DUR_W  = 4;
    localparam int CODE_W = 6;
    localparam int DATA_W = 6;
    localparam logic [CODE_W-1:0] FULL = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwm_in = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [2:0]        seg_id;
    logic              drive_src;
    logic [CODE_W-1:0] i_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gate_slew_seq #(.DUR_W(DUR_W), .CODE_W(CODE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .seg_id(seg_id), .drive_src(drive_src), .i_code(i_code)
    );

    task automatic chk(input string req, input logic [2:0] eseg, input logic esrc,
                       input logic [CODE_W-1:0] ecode);
        n_chk++;
        if (seg_id !== eseg || drive_src !== esrc || i_code !== ecode) begin
            n_fail++;
            $display("FAIL %s: seg=%0d src=%0b code=%0d expected seg=%0d src=%0b code=%0d",
                     req, seg_id, drive_src, i_code, eseg, esrc, ecode);
        end
    endtask

    // R9 register map: 0..3 durations, 4..7 codes
    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // sample the trace that follows an edge driven at the previous negedge
    task automatic trace(input bit on, input int d1, input int d2,
                         input logic [CODE_W-1:0] c1, input logic [CODE_W-1:0] c2);
        for (int t = 0; t <= d1 + d2 + 1; t++) begin
            @(negedge clk);
            if (t < d1)
                chk((d2 == 0) ? "R6 pre" : (on ? "R2" : "R5 pre"), on ? 3'd1 : 3'd4, on, c1);
            else if (t < d1 + d2)
                chk((d1 == 0) ? "R6 main" : (on ? "R3 R9" : "R5 main"), on ? 3'd2 : 3'd5, on, c2);
            else
                chk(on ? "R4" : "R5 hold", on ? 3'd3 : 3'd0, on, FULL);
        end
    endtask

    task automatic sweep_one(input int a, input int b);
        logic [CODE_W-1:0] k;
        k = CODE_W'(a * 4 + b);
        wr(3'd0, DATA_W'(a)); wr(3'd1, DATA_W'(b));
        wr(3'd2, DATA_W'(b)); wr(3'd3, DATA_W'(a));
        wr(3'd4, DATA_W'(k + 1)); wr(3'd5, DATA_W'(k + 17));
        wr(3'd6, DATA_W'(k + 33)); wr(3'd7, DATA_W'(k + 49));
        @(negedge clk); pwm_in = 1'b1;
        trace(1'b1, a, b, k + 1, k + 17);
        @(negedge clk); pwm_in = 1'b0;
        trace(1'b0, b, a, k + 33, k + 49);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 R10 in reset", 3'd0, 1'b0, FULL);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 3'd0, 1'b0, FULL);

        // sweep all small duration pairs, includes every zero-skip pattern (R6)
        for (int a = 0; a <= 3; a++)
            for (int b = 0; b <= 3; b++)
                sweep_one(a, b);
        sweep_one(15, 15);  // largest count for DUR_W = 4

        // R7: abort turn-on mid pre-charge, then abort turn-off mid pre-charge
        wr(3'd0, 6'd4); wr(3'd1, 6'd2); wr(3'd2, 6'd3); wr(3'd3, 6'd1);
        wr(3'd4, 6'd11); wr(3'd6, 6'd7);
        @(negedge clk); pwm_in = 1'b1;
        @(negedge clk); chk("R7 on start", 3'd1, 1'b1, 6'd11);
        @(negedge clk); chk("R7 on running", 3'd1, 1'b1, 6'd11);
        pwm_in = 1'b0;
        @(negedge clk); chk("R7 abort to off", 3'd4, 1'b0, 6'd7);
        pwm_in = 1'b1;
        @(negedge clk); chk("R7 abort to on", 3'd1, 1'b1, 6'd11);
        pwm_in = 1'b0;
        @(negedge clk); chk("R7 off again", 3'd4, 1'b0, 6'd7);
        repeat (4) @(negedge clk);
        chk("R7 off settles", 3'd0, 1'b0, FULL);

        // R8: write mid sequence is deferred
        wr(3'd0, 6'd5); wr(3'd4, 6'd10);
        @(negedge clk); pwm_in = 1'b1;
        @(negedge clk); chk("R8 before write", 3'd1, 1'b1, 6'd10);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 6'd33;
        @(negedge clk); chk("R8 write ignored", 3'd1, 1'b1, 6'd10);
        wr_en = 1'b0;
        @(negedge clk); chk("R8 still old", 3'd1, 1'b1, 6'd10);
        repeat (6) @(negedge clk);
        chk("R8 hold", 3'd3, 1'b1, FULL);
        pwm_in = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 off done", 3'd0, 1'b0, FULL);
        pwm_in = 1'b1;
        @(negedge clk); chk("R8 new code used", 3'd1, 1'b1, 6'd33);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule